// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits on the slave side of a memory port. It lets bus masters run semaphore-style read-modify-write sequences without any bus lock. It watches the accepted requests on a simplified read address channel and a simplified write address channel: the lock bit, the transaction ID, the address and the transfer size. It keeps a small table of reservations, with at most one reservation per ID. For every accepted write it states, one cycle later, whether the response is EXOKAY, OKAY, or OKAY with the memory update suppressed (a failed exclusive).

An exclusive read records a reservation for the aligned granule that holds its address. An exclusive write from the same ID succeeds only if that reservation is still present with the same granule and size, and success consumes the reservation. Any write that actually updates memory removes the reservations of all other IDs on the same granule. Normal reads and writes are never refused. Arbitration is never held, so a competing master only ever causes the later exclusive write to fail.

When every entry is in use, a new exclusive read from an ID that holds no reservation evicts the entry that was allocated least recently.

Top module: `excl_monitor`

## Requirements
- R1: While rst_n is low, and after any reset, the table holds no reservation and b_vld, b_resp and b_inhibit are 0, so the first exclusive write after a reset fails.
- R2: An exclusive read (lock bit 1) records a reservation of ID, granule and size. A later exclusive write with the same ID, the same size and an address in the same granule (address bits below log2(GRAN_BYTES) ignored) answers with b_resp = 2'b01 (EXOKAY) and b_inhibit = 0. Every response appears with b_vld high in the cycle after aw_fire, and b_vld, b_resp and b_inhibit are all 0 in any cycle that follows no write.
- R3: A successful exclusive write removes its reservation, so a repeated exclusive write to that granule fails.
- R4: An exclusive write with no matching reservation (no entry for its ID, a different granule or a different size) answers b_resp = 2'b00 (OKAY) with b_inhibit = 1. It changes no reservation, its own ID's included.
- R5: A write that updates memory (a normal write or a successful exclusive write) removes every reservation that another ID holds on the same granule. Writes to other granules remove nothing.
- R6: A normal write (lock bit 0) always answers OKAY with b_inhibit = 0. A normal write by the holder to its own granule keeps the holder's reservation.
- R7: A normal read never changes any reservation.
- R8: An ID holds at most one reservation. A new exclusive read by an ID that already holds one replaces the old granule.
- R9: When all ENTRIES entries are in use, an exclusive read from an ID that holds no reservation replaces the least recently allocated entry. A re-read by an existing holder counts as a fresh allocation for this ordering.
- R10: When a read and a write are accepted in the same cycle, the write is judged against the table as it stood before that cycle, and then the read's allocation is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| ar_fire | input | 1 | A read address request is accepted this cycle |
| ar_excl | input | 1 | Lock bit of the read: 1 exclusive, 0 normal |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read byte address |
| ar_size | input | 3 | Read transfer size code |
| aw_fire | input | 1 | A write address request is accepted this cycle |
| aw_excl | input | 1 | Lock bit of the write: 1 exclusive, 0 normal |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write byte address |
| aw_size | input | 3 | Write transfer size code |
| b_vld | output | 1 | Verdict for the write accepted in the previous cycle |
| b_resp | output | 2 | 2'b01 EXOKAY, 2'b00 OKAY |
| b_inhibit | output | 1 | Failed exclusive: the memory update must be suppressed |

## Verification
The bench builds the monitor with its default parameters: 4-bit IDs, 32-bit addresses, four entries and a 64-byte granule. With four entries the table fills after four exclusive reads from distinct IDs, which puts eviction and the effect of a refresh on the eviction order within a few vectors. The 64-byte granule lets the vectors pair addresses at the two edges of one granule, which must match, with addresses in the neighbouring granule, which must not.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } xresp_e;

endpackage

// File: rtl/excl_age_matrix.sv
// Allocation-order tracker: older_q[i][j] set means entry i was allocated
// before entry j. The order is total from reset onward, so exactly one
// entry is older than all others.
module excl_age_matrix #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic [N-1:0] alloc_oh,
  output logic [N-1:0] victim_oh
);

  logic [N-1:0][N-1:0] older_q;
  logic [N-1:0][N-1:0] older_d;

  always_comb begin
    older_d = older_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j) begin
          if (alloc_oh[i]) older_d[i][j] = 1'b0;
          else if (alloc_oh[j]) older_d[i][j] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          older_q[i][j] <= (i < j);
        end
      end
    end else if (alloc_en) begin
      older_q <= older_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_victim
    assign victim_oh[g] = &(older_q[g] | ((N)'(1) << g));
  end

  // R9: the replacement choice always names exactly one entry
  a_r9_victim_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim_oh) == 1);

  // R9: a freshly allocated entry is never the next victim
  a_r9_alloc_is_youngest: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en && $countones(alloc_oh) == 1 |=> (victim_oh & $past(alloc_oh)) == '0);

endmodule

// File: rtl/excl_match_unit.sv
// Per-entry comparators against the read and write requests.
module excl_match_unit
  import excl_mon_pkg::*;
#(
  parameter int N      = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                ent_vld,
  input  logic [N-1:0][ID_W-1:0]      ent_id,
  input  logic [N-1:0][ADDR_W-1:0]    ent_base,
  input  logic [N-1:0][SIZE_W-1:0]    ent_size,
  input  logic [ID_W-1:0]             rd_id,
  input  logic [ID_W-1:0]             wr_id,
  input  logic [ADDR_W-1:0]           wr_base,
  input  logic [SIZE_W-1:0]           wr_size,
  output logic [N-1:0]                rd_same_id,
  output logic [N-1:0]                wr_own_hit,
  output logic [N-1:0]                wr_other_hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic id_eq_w;
    logic base_eq_w;
    assign id_eq_w         = (ent_id[g] == wr_id);
    assign base_eq_w       = (ent_base[g] == wr_base);
    assign rd_same_id[g]   = ent_vld[g] && (ent_id[g] == rd_id);
    assign wr_own_hit[g]   = ent_vld[g] && id_eq_w && base_eq_w && (ent_size[g] == wr_size);
    assign wr_other_hit[g] = ent_vld[g] && !id_eq_w && base_eq_w;
  end

  // R8: the table never holds two live entries for one ID
  a_r8_single_rd_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_same_id) <= 1);

  a_r8_single_wr_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_own_hit) <= 1);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 4,
  parameter int GRAN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_fire,
  input  logic              ar_excl,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [2:0]        ar_size,
  input  logic              aw_fire,
  input  logic              aw_excl,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [2:0]        aw_size,
  output logic              b_vld,
  output logic [1:0]        b_resp,
  output logic              b_inhibit
);

  localparam int                GRAN_LSB  = $clog2(GRAN_BYTES);
  localparam logic [ADDR_W-1:0] GRAN_MASK = {ADDR_W{1'b1}} << GRAN_LSB;

  // reservation table
  logic [ENTRIES-1:0]                  ent_vld_q, ent_vld_d;
  logic [ENTRIES-1:0][ID_W-1:0]        ent_id_q;
  logic [ENTRIES-1:0][ADDR_W-1:0]      ent_base_q;
  logic [ENTRIES-1:0][SIZE_W-1:0]      ent_size_q;

  // response registers
  logic   b_vld_q, b_vld_d;
  xresp_e b_resp_q, b_resp_d;
  logic   b_inh_q, b_inh_d;

  logic [ADDR_W-1:0]  rd_base, wr_base;
  logic [ENTRIES-1:0] rd_same_id, wr_own_hit, wr_other_hit;
  logic [ENTRIES-1:0] victim_oh, free_vec, free_first, alloc_oh, clr_vec, kill_vec;
  logic               excl_rd, own_hit, wr_pass, wr_fail, wr_commit;

  assign rd_base = ar_addr & GRAN_MASK;
  assign wr_base = aw_addr & GRAN_MASK;

  excl_match_unit #(
    .N      (ENTRIES),
    .ID_W   (ID_W),
    .ADDR_W (ADDR_W)
  ) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .ent_vld      (ent_vld_q),
    .ent_id       (ent_id_q),
    .ent_base     (ent_base_q),
    .ent_size     (ent_size_q),
    .rd_id        (ar_id),
    .wr_id        (aw_id),
    .wr_base      (wr_base),
    .wr_size      (aw_size),
    .rd_same_id   (rd_same_id),
    .wr_own_hit   (wr_own_hit),
    .wr_other_hit (wr_other_hit)
  );

  excl_age_matrix #(
    .N (ENTRIES)
  ) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (excl_rd),
    .alloc_oh  (alloc_oh),
    .victim_oh (victim_oh)
  );

  // write verdict against the table as it stood before this cycle
  always_comb begin
    own_hit   = |wr_own_hit;
    wr_pass   = aw_fire && aw_excl && own_hit;
    wr_fail   = aw_fire && aw_excl && !own_hit;
    wr_commit = aw_fire && (!aw_excl || own_hit);
    clr_vec   = wr_pass   ? wr_own_hit   : '0;
    kill_vec  = wr_commit ? wr_other_hit : '0;
  end

  // exclusive read allocation: own entry, else lowest free, else oldest
  always_comb begin
    excl_rd    = ar_fire && ar_excl;
    free_vec   = ~ent_vld_q;
    free_first = free_vec & (~free_vec + 1'b1);
    if (!excl_rd)         alloc_oh = '0;
    else if (|rd_same_id) alloc_oh = rd_same_id;
    else if (|free_vec)   alloc_oh = free_first;
    else                  alloc_oh = victim_oh;
  end

  always_comb begin
    ent_vld_d = (ent_vld_q & ~clr_vec & ~kill_vec) | alloc_oh;
    b_vld_d   = aw_fire;
    b_resp_d  = wr_pass ? RESP_EXOKAY : RESP_OKAY;
    b_inh_d   = wr_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld_q <= '0;
      b_vld_q   <= 1'b0;
      b_resp_q  <= RESP_OKAY;
      b_inh_q   <= 1'b0;
    end else begin
      ent_vld_q <= ent_vld_d;
      b_vld_q   <= b_vld_d;
      b_resp_q  <= b_resp_d;
      b_inh_q   <= b_inh_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (alloc_oh[g]) begin
        ent_id_q[g]   <= ar_id;
        ent_base_q[g] <= rd_base;
        ent_size_q[g] <= ar_size;
      end
    end
  end

  assign b_vld     = b_vld_q;
  assign b_resp    = b_resp_q;
  assign b_inhibit = b_inh_q;

  // R2: one verdict per accepted write, in the following cycle
  a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |=> b_vld);

  a_r2_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !aw_fire |=> !b_vld && b_resp == RESP_OKAY && !b_inhibit);

  // R4: suppression only ever accompanies an OKAY verdict
  a_r4_inhibit_is_okay: assert property (@(posedge clk) disable iff (!rst_n)
    b_inhibit |-> b_vld && b_resp == RESP_OKAY);

  // R6: normal writes never fail
  a_r6_normal_write_ok: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire && !aw_excl |=> b_vld && b_resp == RESP_OKAY && !b_inhibit);

  // R3: a consumed reservation is gone unless re-read in the same cycle
  a_r3_success_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass && !excl_rd |=> (ent_vld_q & $past(wr_own_hit)) == '0);

  // R7: without a write or an exclusive read the table stays as it is
  a_r7_table_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !aw_fire && !excl_rd |=> $stable(ent_vld_q));

endmodule

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;

  typedef struct packed {
    logic [23:0] tag;
    logic        rf;
    logic        rx;
    logic [3:0]  rid;
    logic [31:0] ra;
    logic [2:0]  rs;
    logic        wf;
    logic        wx;
    logic [3:0]  wid;
    logic [31:0] wa;
    logic [2:0]  ws;
    logic [3:0]  exp;   // {b_vld, b_resp[1:0], b_inhibit}
  } vec_t;

  localparam logic [3:0] E_EX   = 4'b1010;
  localparam logic [3:0] E_FAIL = 4'b1001;
  localparam logic [3:0] E_NORM = 4'b1000;
  localparam logic [3:0] E_NONE = 4'b0000;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{"R1",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd1, 32'h100, 3'd2, E_FAIL},
    '{"R2",  1'b1,1'b1,4'd1, 32'h104, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R2",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd1, 32'h13C, 3'd2, E_EX},
    '{"R3",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd1, 32'h100, 3'd2, E_FAIL},
    '{"R4",  1'b1,1'b1,4'd2, 32'h200, 3'd3, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R4",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd2, 32'h240, 3'd3, E_FAIL},
    '{"R4",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd2, 32'h200, 3'd2, E_FAIL},
    '{"R4",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd3, 32'h200, 3'd3, E_FAIL},
    '{"R4",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd2, 32'h208, 3'd3, E_EX},
    '{"R5",  1'b1,1'b1,4'd4, 32'h300, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R5",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b0,4'd5, 32'h380, 3'd2, E_NORM},
    '{"R6",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b0,4'd4, 32'h300, 3'd2, E_NORM},
    '{"R7",  1'b1,1'b0,4'd6, 32'h300, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R7",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd4, 32'h300, 3'd2, E_EX},
    '{"R5",  1'b1,1'b1,4'd4, 32'h300, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R5",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b0,4'd5, 32'h33F, 3'd0, E_NORM},
    '{"R5",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd4, 32'h300, 3'd2, E_FAIL},
    '{"R5",  1'b1,1'b1,4'd7, 32'h400, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R5",  1'b1,1'b1,4'd8, 32'h400, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R5",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd7, 32'h400, 3'd2, E_EX},
    '{"R5",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd8, 32'h400, 3'd2, E_FAIL},
    '{"R8",  1'b1,1'b1,4'd9, 32'h500, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R8",  1'b1,1'b1,4'd9, 32'h600, 3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R8",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd9, 32'h500, 3'd2, E_FAIL},
    '{"R8",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd9, 32'h600, 3'd2, E_EX},
    '{"R10", 1'b1,1'b1,4'd10,32'h700, 3'd2, 1'b1,1'b1,4'd10,32'h700, 3'd2, E_FAIL},
    '{"R10", 1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd10,32'h700, 3'd2, E_EX},
    '{"R10", 1'b1,1'b1,4'd11,32'h800, 3'd2, 1'b1,1'b0,4'd12,32'h800, 3'd2, E_NORM},
    '{"R10", 1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd11,32'h800, 3'd2, E_EX},
    '{"R9",  1'b1,1'b1,4'd1, 32'h1000,3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R9",  1'b1,1'b1,4'd2, 32'h1040,3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R9",  1'b1,1'b1,4'd3, 32'h1080,3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R9",  1'b1,1'b1,4'd4, 32'h10C0,3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R9",  1'b1,1'b1,4'd5, 32'h1100,3'd2, 1'b0,1'b0,4'd0, 32'h0,   3'd0, E_NONE},
    '{"R9",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd1, 32'h1000,3'd2, E_FAIL},
    '{"R9",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd2, 32'h1040,3'd2, E_EX},
    '{"R9",  1'b0,1'b0,4'd0, 32'h0,   3'd0, 1'b1,1'b1,4'd5, 32'h1100,3'd2, E_EX}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ar_fire, ar_excl, aw_fire, aw_excl;
  logic [3:0]  ar_id, aw_id;
  logic [31:0] ar_addr, aw_addr;
  logic [2:0]  ar_size, aw_size;
  logic        b_vld, b_inhibit;
  logic [1:0]  b_resp;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  excl_monitor u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ar_fire   (ar_fire),
    .ar_excl   (ar_excl),
    .ar_id     (ar_id),
    .ar_addr   (ar_addr),
    .ar_size   (ar_size),
    .aw_fire   (aw_fire),
    .aw_excl   (aw_excl),
    .aw_id     (aw_id),
    .aw_addr   (aw_addr),
    .aw_size   (aw_size),
    .b_vld     (b_vld),
    .b_resp    (b_resp),
    .b_inhibit (b_inhibit)
  );

  task automatic chk(input logic [23:0] tag, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {b_vld,b_resp,b_inhibit} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // drive one cycle of requests from a negedge, judge at the next negedge
  task automatic step(input vec_t v);
    ar_fire = v.rf;  ar_excl = v.rx; ar_id = v.rid; ar_addr = v.ra; ar_size = v.rs;
    aw_fire = v.wf;  aw_excl = v.wx; aw_id = v.wid; aw_addr = v.wa; aw_size = v.ws;
    @(negedge clk);
    chk(v.tag, {b_vld, b_resp, b_inhibit}, v.exp);
  endtask

  task automatic idle();
    ar_fire = 1'b0; ar_excl = 1'b0; ar_id = '0; ar_addr = '0; ar_size = '0;
    aw_fire = 1'b0; aw_excl = 1'b0; aw_id = '0; aw_addr = '0; aw_size = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1..: run actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    chk("R1", {b_vld, b_resp, b_inhibit}, E_NONE);  // reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i]);
    end
    idle();
    @(negedge clk);

    // R1: reset mid-run drops a live reservation
    step('{"R1", 1'b1,1'b1,4'd6, 32'h2000,3'd2, 1'b0,1'b0,4'd0, 32'h0,3'd0, E_NONE});
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", {b_vld, b_resp, b_inhibit}, E_NONE);
    rst_n = 1'b1;
    step('{"R1", 1'b0,1'b0,4'd0, 32'h0,3'd0, 1'b1,1'b1,4'd6, 32'h2000,3'd2, E_FAIL});

    // R9: a re-read by a holder refreshes its age, so the next oldest goes
    step('{"R9", 1'b1,1'b1,4'd1, 32'h3000,3'd1, 1'b0,1'b0,4'd0, 32'h0,3'd0, E_NONE});
    step('{"R9", 1'b1,1'b1,4'd2, 32'h3040,3'd1, 1'b0,1'b0,4'd0, 32'h0,3'd0, E_NONE});
    step('{"R9", 1'b1,1'b1,4'd3, 32'h3080,3'd1, 1'b0,1'b0,4'd0, 32'h0,3'd0, E_NONE});
    step('{"R9", 1'b1,1'b1,4'd4, 32'h30C0,3'd1, 1'b0,1'b0,4'd0, 32'h0,3'd0, E_NONE});
    step('{"R9", 1'b1,1'b1,4'd1, 32'h3000,3'd1, 1'b0,1'b0,4'd0, 32'h0,3'd0, E_NONE});
    step('{"R9", 1'b1,1'b1,4'd5, 32'h3100,3'd1, 1'b0,1'b0,4'd0, 32'h0,3'd0, E_NONE});
    step('{"R9", 1'b0,1'b0,4'd0, 32'h0,3'd0, 1'b1,1'b1,4'd2, 32'h3040,3'd1, E_FAIL});
    step('{"R9", 1'b0,1'b0,4'd0, 32'h0,3'd0, 1'b1,1'b1,4'd1, 32'h3000,3'd1, E_EX});
    step('{"R9", 1'b0,1'b0,4'd0, 32'h0,3'd0, 1'b1,1'b1,4'd3, 32'h3080,3'd1, E_EX});
    idle();
    @(negedge clk);
    chk("R2", {b_vld, b_resp, b_inhibit}, E_NONE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule